// File: doc/BRIEF.md
# Serial EEPROM boot image loader

This block sits between a serial memory reader and on-chip memory during boot. It takes in a byte stream that has been read from an EEPROM in 32-byte pages and copies the boot data into one of two on-chip memories. The image is made up of one or more transfer blocks. Each block opens with an 8-byte header, which gives a password, a page count, a chaining flag and a 16-bit start address. Payload bytes follow the header.

The password is judged only in the first block. If it is wrong, the loader switches to host serial mode and takes no further bytes. If it is right, the loader writes the payload of every block to incrementing addresses. It then moves on to the next block until a block flagged as final has been written, and signals completion with a one-cycle pulse. The input uses a valid/ready handshake. The payload passes straight through to a memory write port, and that port's ready signal stalls the input.

Top module: `boot_image_loader`

## Requirements
- R1: After reset, in_ready is 1, wr_valid is 0, mode_valid is 0 and done is 0.
- R2: If the first byte accepted after reset equals 0xA5, mode_valid and mode_eeprom both become 1 in the next cycle and stay constant until reset.
- R3: If the first byte accepted after reset differs from 0xA5, mode_valid becomes 1 and mode_eeprom 0 in the next cycle. From then on in_ready stays 0 and no write is issued.
- R4: The first header byte of the second and later blocks has no effect on loading, whatever its value.
- R5: Header byte 1 is the page count N, and a page holds 32 bytes. A block writes 24 payload bytes when N is 0 or 1, and 24 + 32·(N−1) bytes otherwise.
- R6: Header bytes 3 (high) and 4 (low) give the start address. Successive payload writes of a block go to consecutive addresses, wrapping modulo 2^16.
- R7: wr_sram is 1 for every write of a block whose address high byte equals 0xFF, and 0 otherwise.
- R8: Header byte 2 equal to 0x00 marks the final block. Any other value makes the byte that follows the block's last payload byte the first header byte of a new block.
- R9: Header bytes 0 to 7 are never written to memory. Bytes 5 to 7 are discarded.
- R10: While a payload byte is offered and wr_ready is 0, in_ready is 0 and wr_addr and wr_sram hold their values.
- R11: done is a single-cycle pulse in the cycle after the final payload write. After done, in_ready and wr_valid stay 0.
- R12: wr_data carries the payload byte being written, in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte offered |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| wr_sram | output | 1 | Target select: 1 internal SRAM, 0 XRAM |
| mode_valid | output | 1 | Boot mode has been decided |
| mode_eeprom | output | 1 | 1 EEPROM download, 0 host serial |
| done | output | 1 | One-cycle pulse when loading ends |

## Verification
The assertions assume that the stream source keeps in_valid and in_data steady until the byte is accepted. They also assume that reset is held for at least one clock edge before any byte is offered. The bench drives each byte only on falling edges, holds it until it sees in_ready high, and changes wr_ready only on falling edges using a pseudo-random pattern. It therefore never withdraws a byte that is waiting for acceptance.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

   typedef enum logic [1:0] {
      LD_HEADER = 2'd0,
      LD_PAYLOAD = 2'd1,
      LD_HOST = 2'd2,
      LD_FINISHED = 2'd3
   } ldr_state_e;

   // Header byte positions; the loader's behaviour depends on this order
   localparam int unsigned HB_PASSWORD = 0;
   localparam int unsigned HB_PAGES = 1;
   localparam int unsigned HB_CHAIN = 2;
   localparam int unsigned HB_ADDR_HI = 3;
   localparam int unsigned HB_ADDR_LO = 4;

endpackage

// File: rtl/boot_ldr_hdr.sv
module boot_ldr_hdr
   import boot_ldr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned HDR_BYTES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic [DATA_W-1:0]     byte_in,
   output logic                  at_password,
   output logic                  at_final,
   output logic [DATA_W-1:0]     pages,
   output logic                  chain_more,
   output logic [2*DATA_W-1:0]   base_addr
);
   localparam int unsigned IDX_W = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] pages_q;
   logic [DATA_W-1:0] chain_q;
   logic [DATA_W-1:0] hi_q;
   logic [DATA_W-1:0] lo_q;

   assign at_password = (idx_q == IDX_W'(HB_PASSWORD));
   assign at_final    = (idx_q == IDX_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (take) begin
         idx_q <= at_final ? '0 : idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pages_q <= '0;
         chain_q <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else if (take) begin
         if (idx_q == IDX_W'(HB_PAGES))   pages_q <= byte_in;
         if (idx_q == IDX_W'(HB_CHAIN))   chain_q <= byte_in;
         if (idx_q == IDX_W'(HB_ADDR_HI)) hi_q    <= byte_in;
         if (idx_q == IDX_W'(HB_ADDR_LO)) lo_q    <= byte_in;
      end
   end

   assign pages      = pages_q;
   assign chain_more = (chain_q != '0);
   assign base_addr  = {hi_q, lo_q};

endmodule

// File: rtl/boot_ldr_addr.sv
module boot_ldr_addr #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned HDR_BYTES = 8,
   parameter logic [DATA_W-1:0] SRAM_HI = 8'hFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [2*DATA_W-1:0]   base_addr,
   input  logic [DATA_W-1:0]     pages,
   input  logic                  step,
   output logic [2*DATA_W-1:0]   addr,
   output logic                  sram_sel,
   output logic                  last_beat
);
   localparam int unsigned ADDR_W = 2 * DATA_W;
   localparam int unsigned MAX_LEN = PAGE_BYTES * (2 ** DATA_W);
   localparam int unsigned REM_W = $clog2(MAX_LEN + 1);
   localparam logic [REM_W-1:0] FIRST_LEN = REM_W'(PAGE_BYTES - HDR_BYTES);

   logic [DATA_W-1:0] extra_pages;
   logic [REM_W-1:0]  extra_len;
   logic [REM_W-1:0]  rem_q;
   logic [ADDR_W-1:0] addr_q;
   logic              sram_q;

   assign extra_pages = (pages <= DATA_W'(1)) ? '0 : pages - 1'b1;

   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) == 0) begin : g_len_shift
         localparam int unsigned SHIFT = $clog2(PAGE_BYTES);
         assign extra_len = REM_W'(extra_pages) << SHIFT;
      end else begin : g_len_mul
         assign extra_len = REM_W'(extra_pages) * REM_W'(PAGE_BYTES);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         addr_q <= '0;
         sram_q <= 1'b0;
      end else if (load) begin
         rem_q  <= FIRST_LEN + extra_len;
         addr_q <= base_addr;
         sram_q <= (base_addr[ADDR_W-1 -: DATA_W] == SRAM_HI);
      end else if (step) begin
         rem_q  <= rem_q - 1'b1;
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr      = addr_q;
   assign sram_sel  = sram_q;
   assign last_beat = (rem_q == REM_W'(1));

endmodule

// File: rtl/boot_ldr_fsm.sv
module boot_ldr_fsm
   import boot_ldr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic wr_ready,
   input  logic at_password,
   input  logic at_final,
   input  logic pwd_match,
   input  logic chain_more,
   input  logic last_beat,
   output logic in_ready,
   output logic wr_valid,
   output logic hdr_take,
   output logic data_step,
   output logic addr_load,
   output logic mode_valid,
   output logic mode_eeprom,
   output logic done
);
   ldr_state_e st_q, st_d;
   logic first_q;
   logic mval_q, meep_q, done_q;
   logic judge;

   assign in_ready  = (st_q == LD_HEADER) || ((st_q == LD_PAYLOAD) && wr_ready);
   assign wr_valid  = (st_q == LD_PAYLOAD) && in_valid;
   assign hdr_take  = (st_q == LD_HEADER) && in_valid;
   assign data_step = (st_q == LD_PAYLOAD) && in_valid && wr_ready;
   assign addr_load = hdr_take && at_final;
   assign judge     = hdr_take && at_password && first_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LD_HEADER: begin
            if (judge && !pwd_match) st_d = LD_HOST;
            else if (addr_load)      st_d = LD_PAYLOAD;
         end
         LD_PAYLOAD: begin
            if (data_step && last_beat) st_d = chain_more ? LD_HEADER : LD_FINISHED;
         end
         LD_HOST:     st_d = LD_HOST;
         LD_FINISHED: st_d = LD_FINISHED;
         default:     st_d = LD_HEADER;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= LD_HEADER;
         first_q <= 1'b1;
         mval_q  <= 1'b0;
         meep_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= data_step && last_beat && !chain_more;
         if (judge) begin
            first_q <= 1'b0;
            mval_q  <= 1'b1;
            meep_q  <= pwd_match;
         end
      end
   end

   assign mode_valid  = mval_q;
   assign mode_eeprom = meep_q;
   assign done        = done_q;

endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned HDR_BYTES = 8,
   parameter logic [DATA_W-1:0] PASSWORD = 8'hA5,
   parameter logic [DATA_W-1:0] SRAM_HI = 8'hFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DATA_W-1:0]   in_data,
   output logic                in_ready,
   output logic                wr_valid,
   input  logic                wr_ready,
   output logic [2*DATA_W-1:0] wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                wr_sram,
   output logic                mode_valid,
   output logic                mode_eeprom,
   output logic                done
);
   localparam int unsigned ADDR_W = 2 * DATA_W;

   generate
      if (HDR_BYTES < 5) begin : g_bad_hdr
         $error("header must hold at least five bytes");
      end
      if (PAGE_BYTES <= HDR_BYTES) begin : g_bad_page
         $error("page must be longer than the header");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("byte width too small");
      end
   endgenerate

   logic              at_password, at_final, chain_more, last_beat;
   logic              hdr_take, data_step, addr_load;
   logic [DATA_W-1:0] pages;
   logic [ADDR_W-1:0] base_addr;
   logic              pwd_match;

   assign pwd_match = (in_data == PASSWORD);
   assign wr_data   = in_data;

   boot_ldr_hdr #(
      .DATA_W(DATA_W),
      .HDR_BYTES(HDR_BYTES)
   ) u_hdr (
      .clk(clk),
      .rst_n(rst_n),
      .take(hdr_take),
      .byte_in(in_data),
      .at_password(at_password),
      .at_final(at_final),
      .pages(pages),
      .chain_more(chain_more),
      .base_addr(base_addr)
   );

   boot_ldr_addr #(
      .DATA_W(DATA_W),
      .PAGE_BYTES(PAGE_BYTES),
      .HDR_BYTES(HDR_BYTES),
      .SRAM_HI(SRAM_HI)
   ) u_addr (
      .clk(clk),
      .rst_n(rst_n),
      .load(addr_load),
      .base_addr(base_addr),
      .pages(pages),
      .step(data_step),
      .addr(wr_addr),
      .sram_sel(wr_sram),
      .last_beat(last_beat)
   );

   boot_ldr_fsm u_fsm (
      .clk(clk),
      .rst_n(rst_n),
      .in_valid(in_valid),
      .wr_ready(wr_ready),
      .at_password(at_password),
      .at_final(at_final),
      .pwd_match(pwd_match),
      .chain_more(chain_more),
      .last_beat(last_beat),
      .in_ready(in_ready),
      .wr_valid(wr_valid),
      .hdr_take(hdr_take),
      .data_step(data_step),
      .addr_load(addr_load),
      .mode_valid(mode_valid),
      .mode_eeprom(mode_eeprom),
      .done(done)
   );

endmodule

// File: rtl/boot_ldr_chk.sv
module boot_ldr_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_sram,
   input logic              mode_valid,
   input logic              mode_eeprom,
   input logic              done
);
   assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |=> (mode_valid && $stable(mode_eeprom)));

   assert_host_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_valid && !mode_eeprom) |-> (!in_ready && !wr_valid));

   assert_write_needs_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (mode_valid && mode_eeprom));

   assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |-> !in_ready);

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> $stable(wr_addr));

   assert_target_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> $stable(wr_sram));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!in_ready && !wr_valid && mode_eeprom));

endmodule

bind boot_image_loader boot_ldr_chk #(.ADDR_W(2 * DATA_W)) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .in_ready(in_ready),
   .wr_valid(wr_valid),
   .wr_ready(wr_ready),
   .wr_addr(wr_addr),
   .wr_sram(wr_sram),
   .mode_valid(mode_valid),
   .mode_eeprom(mode_eeprom),
   .done(done)
);

// File: tb/boot_image_loader_bench.sv
`timescale 1ns / 10ps
module boot_image_loader_bench;
   localparam int MAXN = 16384;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic        wr_valid;
   logic        wr_ready = 1'b1;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic        wr_sram;
   logic        mode_valid, mode_eeprom, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [7:0]  strm [MAXN];
   logic [15:0] ex_addr [MAXN];
   logic [7:0]  ex_data [MAXN];
   logic        ex_sram [MAXN];
   int n_strm, n_exp, n_wr, n_done;
   logic expect_done = 1'b0;
   logic stall_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   boot_image_loader u_boot_image_loader (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_sram(wr_sram),
      .mode_valid(mode_valid), .mode_eeprom(mode_eeprom), .done(done)
   );

   task automatic check(input logic ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
   end

   // Observation point: after drivers have settled, well before the next rising edge
   always @(negedge clk) begin
      #0.4;
      if (rst_n) begin
         if (expect_done) begin
            check(done == 1'b1, "R11", "done after final write", done, 1);
            expect_done = 1'b0;
         end
         if (done) n_done++;
         if (wr_valid && !wr_ready)
            check(in_ready == 1'b0, "R10", "in_ready under stall", in_ready, 0);
         if (wr_valid && wr_ready) begin
            if (n_wr >= n_exp) begin
               check(1'b0, "R9", "unexpected write", n_wr, n_exp);
            end else begin
               check(wr_addr == ex_addr[n_wr], "R6", "write address", wr_addr, ex_addr[n_wr]);
               check(wr_data == ex_data[n_wr], "R12", "write data", wr_data, ex_data[n_wr]);
               check(wr_sram == ex_sram[n_wr], "R7", "target select", wr_sram, ex_sram[n_wr]);
               if (n_wr == n_exp - 1) expect_done = 1'b1;
            end
            n_wr++;
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      n_strm = 0; n_exp = 0; n_wr = 0; n_done = 0;
      expect_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push(input logic [7:0] b);
      strm[n_strm] = b;
      n_strm++;
   endtask

   task automatic add_block(input logic [7:0] pwd, input logic [7:0] pc,
                            input logic [7:0] chain, input logic [15:0] base,
                            input int seed);
      int len;
      push(pwd); push(pc); push(chain); push(base[15:8]); push(base[7:0]);
      push(8'hA5); push(8'h5A); push(8'hFF);
      len = 24 + 32 * ((pc <= 1) ? 0 : (int'(pc) - 1));
      for (int i = 0; i < len; i++) begin
         logic [7:0] d;
         d = 8'(seed * 31 + i * 7 + 3);
         push(d);
         ex_addr[n_exp] = base + 16'(i);
         ex_data[n_exp] = d;
         ex_sram[n_exp] = (base[15:8] == 8'hFF);
         n_exp++;
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data = b;
      #0.2;
      while (!in_ready) begin
         @(negedge clk);
         #0.2;
      end
      @(posedge clk);
   endtask

   task automatic play(input string tag);
      int guard;
      for (int k = 0; k < n_strm; k++) send(strm[k]);
      @(negedge clk);
      in_valid = 1'b0;
      guard = 0;
      while (n_done == 0 && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      #0.6;
      check(n_wr == n_exp, "R5", {tag, " write count"}, n_wr, n_exp);
      check(n_done == 1, "R11", {tag, " done pulses"}, n_done, 1);
      check(mode_valid && mode_eeprom, "R2", {tag, " eeprom mode"},
            {mode_valid, mode_eeprom}, 3);
      check(in_ready == 1'b0 && wr_valid == 1'b0, "R11", {tag, " idle after done"},
            {in_ready, wr_valid}, 0);
   endtask

   task automatic bad_password(input logic [7:0] pwd);
      do_reset();
      send(pwd);
      @(negedge clk);
      in_data = 8'hA5;
      #0.6;
      check(mode_valid == 1'b1 && mode_eeprom == 1'b0, "R3", "host mode",
            {mode_valid, mode_eeprom}, 2);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         #0.6;
         check(in_ready == 1'b0 && wr_valid == 1'b0, "R3", "no intake in host mode",
               {in_ready, wr_valid}, 0);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      do_reset();
      #0.6;
      check(in_ready == 1'b1 && wr_valid == 1'b0 && mode_valid == 1'b0 && done == 1'b0,
            "R1", "reset state", {in_ready, wr_valid, mode_valid, done}, 8);

      // R3: wrong first password values
      bad_password(8'h5A);
      bad_password(8'hA4);
      bad_password(8'h00);

      // R5, R6, R7: single-block sweep over small page counts
      for (int pc = 0; pc < 6; pc++) begin
         do_reset();
         stall_en = (pc % 2) == 1;
         add_block(8'hA5, 8'(pc), 8'h00,
                   (pc % 2 == 0) ? 16'hFF00 + 16'(pc * 5) : 16'h1200 + 16'(pc * 9), pc);
         play("R5 single block");
      end

      // R4, R8, R9: chained blocks, later passwords arbitrary, nonzero chain values
      do_reset();
      stall_en = 1'b1;
      add_block(8'hA5, 8'd2, 8'h01, 16'h4000, 11);
      add_block(8'h00, 8'd1, 8'h80, 16'hFF10, 12);
      add_block(8'h33, 8'd3, 8'h00, 16'h20F8, 13);
      play("R4 R8 chain");

      do_reset();
      stall_en = 1'b0;
      add_block(8'hA5, 8'd0, 8'hFF, 16'hFEFC, 21);
      add_block(8'h5A, 8'd0, 8'h00, 16'hFFFA, 22);
      play("R8 back to back");

      // R6 R10: full-length block with address wrap under stalls
      do_reset();
      stall_en = 1'b1;
      add_block(8'hA5, 8'd255, 8'h00, 16'hFFF0, 5);
      play("R6 R10 long block");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule